// File: doc/BRIEF.md
# EEPROM Row Programming Controller

This block sits between a CPU-style register bus and a 128-byte non-volatile data array. It can program one byte at a time or up to eight bytes of one row in a single programming cycle. Software drives it through one control register and through the array addresses. The array is modelled as ordinary synthesizable storage that only this controller may write. A counter models the programming time.

For a single-byte update, software sets the write enable and writes the array address. For a row update, software first sets the row-mode bit, which empties the eight volatile row latches. It then writes the bytes it wants to change. The first of these writes fixes the row. Finally it sets the start bit. Only the latched bytes are programmed. When the cycle ends, the hardware clears both row mode and start. While the cycle runs, array accesses are refused. A standby bit takes the array offline.

Top module: `nvm_row_prog`

## Requirements
- R1: After reset, the control register reads 00h and every array byte reads 00h.
- R2: The control register, at address 80h, reads back as follows: bit 6 standby, bit 3 start, bit 2 row mode, bit 1 busy and bit 0 write enable. Bits 7, 5 and 4 always read 0. Any address that is neither an array address (00h-7Fh) nor 80h reads 00h. Read data appears on the cycle after the read strobe.
- R3: With row mode clear and write enable set, a write to an array address starts a programming cycle. Busy stays set for exactly PROG_CYCLES clock cycles. The byte reads the new value afterwards.
- R4: With write enable clear, array writes change nothing and start no cycle.
- R5: A row cycle programs only the bytes written since row mode was most recently entered.
- R6: In row mode, the first array write fixes the row, which is address bits [6:3]. Writes to any other row are ignored.
- R7: Bytes of the fixed row that were not written in row mode keep their old contents after the row cycle.
- R8: Setting the start bit takes effect only when write enable and row mode were both already set. Otherwise start reads 0 and no cycle begins.
- R9: When the start bit is accepted, busy and start read 1 until the cycle ends. At the end, start and row mode clear by themselves.
- R10: Clearing row mode before start throws away the latched bytes and leaves the array unchanged.
- R11: While busy, array writes are ignored, array reads return 00h and control writes are ignored. The cycle in progress still completes.
- R12: While standby is set, array writes are ignored and array reads return 00h. The stored contents return once standby is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Bus address (array 00h-7Fh, control 80h) |
| busWdata | input | 8 | Bus write data |
| busWr | input | 1 | Write strobe, one cycle per access |
| busRd | input | 1 | Read strobe, one cycle per access |
| busRdata | output | 8 | Read data, registered, valid the cycle after busRd |

## Verification
Some properties are checked on every cycle. Each busy period must last exactly PROG_CYCLES cycles. A cycle may begin only with write enable set, and start may rise only when write enable and row mode were already set. Both mode bits must have cleared when busy falls. Reserved control bits must read zero, and array reads during busy or standby must return zero. Other properties depend on memory contents, and only the directed scenarios can show them: which bytes of a row were committed, the row capture by the first write, the discard when row mode is left, and the stored data surviving standby and refused accesses.

// File: rtl/nvm_row_pkg.sv
package nvm_row_pkg;
  // control register bit positions (software decodes these)
  localparam int CtlStandbyBit = 6;
  localparam int CtlStartBit   = 3;
  localparam int CtlRowBit     = 2;
  localparam int CtlBusyBit    = 1;
  localparam int CtlWrEnBit    = 0;

  // strobes from control to datapath
  typedef struct packed {
    logic clrLatch;     // empty row latches and forget the captured row
    logic loadLatch;    // store bus byte into a row latch
    logic startSingle;  // capture address/data for a single-byte cycle
    logic commitSingle; // write the pending byte into the array
    logic commitRow;    // write every valid latch into the array
  } dpStrobe_t;
endpackage

// File: rtl/nvm_row_ctl.sv
module nvm_row_ctl
  import nvm_row_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int ARRAY_BYTES = 128,
  parameter int CTRL_ADDR   = 128,
  parameter int PROG_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busWr,
  input  logic              rowHit,
  output dpStrobe_t         stb,
  output logic [DATA_W-1:0] ctlView,
  output logic              arrBlocked
);
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);

  logic             wrEn, rowMode, startBit, standby, busy, busyRow;
  logic [CNT_W-1:0] cnt;

  logic isArr, isCtl, ctlWr, arrWrOk, done, startRow;
  logic newRow, newStart, newWrEn, newStandby;

  assign isArr      = int'(busAddr) < ARRAY_BYTES;
  assign isCtl      = busAddr == ADDR_W'(CTRL_ADDR);
  assign done       = busy && (cnt == '0);
  assign ctlWr      = busWr && isCtl && !busy;
  assign arrWrOk    = busWr && isArr && !busy && !standby && wrEn;
  assign newRow     = busWdata[CtlRowBit];
  assign newStart   = busWdata[CtlStartBit];
  assign newWrEn    = busWdata[CtlWrEnBit];
  assign newStandby = busWdata[CtlStandbyBit];
  assign startRow   = ctlWr && newStart && newRow && rowMode && wrEn;

  always_comb begin
    stb              = '0;
    stb.clrLatch     = done || (ctlWr && (newRow != rowMode));
    stb.loadLatch    = arrWrOk && rowMode && rowHit;
    stb.startSingle  = arrWrOk && !rowMode;
    stb.commitSingle = done && !busyRow;
    stb.commitRow    = done && busyRow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrEn     <= 1'b0;
      rowMode  <= 1'b0;
      startBit <= 1'b0;
      standby  <= 1'b0;
      busy     <= 1'b0;
      busyRow  <= 1'b0;
      cnt      <= '0;
    end else if (done) begin
      busy     <= 1'b0;
      startBit <= 1'b0;
      rowMode  <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end else if (ctlWr) begin
      wrEn    <= newWrEn;
      standby <= newStandby;
      rowMode <= newRow;
      if (startRow) begin
        startBit <= 1'b1;
        busy     <= 1'b1;
        busyRow  <= 1'b1;
        cnt      <= CNT_W'(PROG_CYCLES - 1);
      end
    end else if (stb.startSingle) begin
      busy    <= 1'b1;
      busyRow <= 1'b0;
      cnt     <= CNT_W'(PROG_CYCLES - 1);
    end
  end

  always_comb begin
    ctlView                = '0;
    ctlView[CtlStandbyBit] = standby;
    ctlView[CtlStartBit]   = startBit;
    ctlView[CtlRowBit]     = rowMode;
    ctlView[CtlBusyBit]    = busy;
    ctlView[CtlWrEnBit]    = wrEn;
  end

  assign arrBlocked = busy || standby;
endmodule

// File: rtl/nvm_row_dp.sv
module nvm_row_dp
  import nvm_row_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int ARRAY_BYTES = 128,
  parameter int ROW_BYTES   = 8,
  parameter int CTRL_ADDR   = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busRd,
  input  dpStrobe_t         stb,
  input  logic [DATA_W-1:0] ctlView,
  input  logic              arrBlocked,
  output logic              rowHit,
  output logic [DATA_W-1:0] busRdata
);
  localparam int IDX_W = $clog2(ARRAY_BYTES);
  localparam int SEL_W = $clog2(ROW_BYTES);
  localparam int ROW_W = IDX_W - SEL_W;

  logic [DATA_W-1:0]    mem       [ARRAY_BYTES];
  logic [DATA_W-1:0]    latchData [ROW_BYTES];
  logic [ROW_BYTES-1:0] latchValid;
  logic [ROW_BYTES-1:0] byteLoad;
  logic [ROW_W-1:0]     rowAddr;
  logic                 rowValid;
  logic [IDX_W-1:0]     pendIdx;
  logic [DATA_W-1:0]    pendData;

  logic [IDX_W-1:0] idx;
  logic [SEL_W-1:0] sel;
  logic [ROW_W-1:0] row;
  logic             isArr, isCtl;

  assign idx    = busAddr[IDX_W-1:0];
  assign sel    = idx[SEL_W-1:0];
  assign row    = idx[IDX_W-1:SEL_W];
  assign isArr  = int'(busAddr) < ARRAY_BYTES;
  assign isCtl  = busAddr == ADDR_W'(CTRL_ADDR);
  assign rowHit = !rowValid || (row == rowAddr);

  // per-byte latch select
  for (genvar b = 0; b < ROW_BYTES; b++) begin : g_sel
    assign byteLoad[b] = stb.loadLatch && (sel == SEL_W'(b));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchValid <= '0;
      rowValid   <= 1'b0;
      rowAddr    <= '0;
      for (int b = 0; b < ROW_BYTES; b++) latchData[b] <= '0;
    end else if (stb.clrLatch) begin
      latchValid <= '0;
      rowValid   <= 1'b0;
    end else if (stb.loadLatch) begin
      if (!rowValid) begin
        rowValid <= 1'b1;
        rowAddr  <= row;
      end
      latchValid <= latchValid | byteLoad;
      for (int b = 0; b < ROW_BYTES; b++)
        if (byteLoad[b]) latchData[b] <= busWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendIdx  <= '0;
      pendData <= '0;
    end else if (stb.startSingle) begin
      pendIdx  <= idx;
      pendData <= busWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ARRAY_BYTES; i++) mem[i] <= '0;
    end else if (stb.commitSingle) begin
      mem[pendIdx] <= pendData;
    end else if (stb.commitRow) begin
      for (int b = 0; b < ROW_BYTES; b++)
        if (latchValid[b]) mem[{rowAddr, b[SEL_W-1:0]}] <= latchData[b];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdata <= '0;
    end else if (busRd) begin
      if (isArr)      busRdata <= arrBlocked ? '0 : mem[idx];
      else if (isCtl) busRdata <= ctlView;
      else            busRdata <= '0;
    end
  end
endmodule

// File: rtl/nvm_row_prog.sv
module nvm_row_prog
  import nvm_row_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int ARRAY_BYTES = 128,
  parameter int ROW_BYTES   = 8,
  parameter int CTRL_ADDR   = 128,
  parameter int PROG_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busWr,
  input  logic              busRd,
  output logic [DATA_W-1:0] busRdata
);
  dpStrobe_t         stb;
  logic [DATA_W-1:0] ctlView;
  logic              arrBlocked;
  logic              rowHit;

  nvm_row_ctl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ARRAY_BYTES(ARRAY_BYTES),
    .CTRL_ADDR(CTRL_ADDR), .PROG_CYCLES(PROG_CYCLES)
  ) i_ctl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWr(busWr), .rowHit(rowHit), .stb(stb), .ctlView(ctlView),
    .arrBlocked(arrBlocked)
  );

  nvm_row_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ARRAY_BYTES(ARRAY_BYTES),
    .ROW_BYTES(ROW_BYTES), .CTRL_ADDR(CTRL_ADDR)
  ) i_dp (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busRd(busRd), .stb(stb), .ctlView(ctlView), .arrBlocked(arrBlocked),
    .rowHit(rowHit), .busRdata(busRdata)
  );
endmodule

// File: rtl/nvm_row_prog_chk.sv
module nvm_row_prog_chk
  import nvm_row_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int ARRAY_BYTES = 128,
  parameter int CTRL_ADDR   = 128,
  parameter int PROG_CYCLES = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRd,
  input logic [DATA_W-1:0] busRdata,
  input logic [DATA_W-1:0] ctlView
);
  logic busyB, startB, rowB, wrEnB, standbyB, arrRd, ctlRd;
  int   busyLen;

  assign busyB    = ctlView[CtlBusyBit];
  assign startB   = ctlView[CtlStartBit];
  assign rowB     = ctlView[CtlRowBit];
  assign wrEnB    = ctlView[CtlWrEnBit];
  assign standbyB = ctlView[CtlStandbyBit];
  assign arrRd    = busRd && (int'(busAddr) < ARRAY_BYTES);
  assign ctlRd    = busRd && (busAddr == ADDR_W'(CTRL_ADDR));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      busyLen <= 0;
    else if (busyB) busyLen <= busyLen + 1;
    else            busyLen <= 0;
  end

  assert_busy_len_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyB) |-> busyLen == PROG_CYCLES);

  assert_needs_wren_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyB) |-> $past(wrEnB));

  assert_start_interlock_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(startB) |-> ($past(wrEnB) && $past(rowB)));

  assert_auto_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyB) |-> (!startB && !rowB));

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctlRd |=> (busRdata[7] == 1'b0 && busRdata[5:4] == 2'b00));

  assert_busy_read_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    (arrRd && busyB) |=> busRdata == '0);

  assert_standby_read_zero_R12: assert property (@(posedge clk) disable iff (!rstN)
    (arrRd && standbyB) |=> busRdata == '0);
endmodule

bind nvm_row_prog nvm_row_prog_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ARRAY_BYTES(ARRAY_BYTES),
  .CTRL_ADDR(CTRL_ADDR), .PROG_CYCLES(PROG_CYCLES)
) i_nvmChk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd),
  .busRdata(busRdata), .ctlView(ctlView)
);

// File: tb/test_nvm_row_prog.sv
module test_nvm_row_prog;
  localparam int PROG = 20;
  localparam logic [7:0] CTL = 8'h80;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic [7:0] busRdata;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  nvm_row_prog #(.PROG_CYCLES(PROG)) i_nvm_row_prog (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWr(busWr), .busRd(busRd), .busRdata(busRdata)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [7:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [7:0] d);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    d = busRdata;
  endtask

  task automatic expectRead(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] d;
    busRead(a, d);
    chk(req, d, exp);
  endtask

  task automatic waitIdle();
    repeat (PROG + 3) @(negedge clk);
  endtask

  task automatic t_reset();
    expectRead("R1 ctl after reset", CTL, 8'h00);
    expectRead("R1 array after reset", 8'h05, 8'h00);
    expectRead("R2 unmapped address", 8'h93, 8'h00);
  endtask

  task automatic t_single();
    logic [7:0] d;
    int busyCnt = 0;
    busWrite(CTL, 8'h01);
    expectRead("R2 wren readback", CTL, 8'h01);
    busWrite(8'h12, 8'hA5);
    for (int i = 0; i < PROG + 5; i++) begin
      busRead(CTL, d);
      if (d[1]) busyCnt++;
      else break;
    end
    chk("R3 busy length", 8'(busyCnt), 8'(PROG));
    expectRead("R3 single byte stored", 8'h12, 8'hA5);
  endtask

  task automatic t_wrdis();
    busWrite(CTL, 8'h00);
    busWrite(8'h13, 8'h3C);
    expectRead("R4 no busy without wren", CTL, 8'h00);
    waitIdle();
    expectRead("R4 write ignored", 8'h13, 8'h00);
  endtask

  task automatic t_ctlbits();
    busWrite(CTL, 8'hB1);
    expectRead("R2 reserved bits read zero", CTL, 8'h01);
    busWrite(CTL, 8'h00);
  endtask

  task automatic t_interlock();
    busWrite(CTL, 8'h09);
    expectRead("R8 start without row mode", CTL, 8'h01);
    busWrite(CTL, 8'h0D);
    expectRead("R8 start in same write as row entry", CTL, 8'h05);
    busWrite(CTL, 8'h00);
    busWrite(CTL, 8'h04);
    busWrite(CTL, 8'h0C);
    expectRead("R8 start without wren", CTL, 8'h04);
    busWrite(CTL, 8'h01);
  endtask

  task automatic t_row_partial();
    for (int i = 0; i < 8; i++) begin
      busWrite(8'h20 + 8'(i), 8'h10 + 8'(i));
      waitIdle();
    end
    busWrite(CTL, 8'h05);
    busWrite(8'h21, 8'hA1);
    busWrite(8'h23, 8'hA3);
    busWrite(8'h26, 8'hA6);
    busWrite(8'h31, 8'hEE);
    busWrite(CTL, 8'h0D);
    expectRead("R9 start and busy visible", CTL, 8'h0F);
    waitIdle();
    expectRead("R9 mode bits auto clear", CTL, 8'h01);
    for (int i = 0; i < 8; i++) begin
      logic [7:0] exp;
      exp = (i == 1 || i == 3 || i == 6) ? (8'hA0 + 8'(i)) : (8'h10 + 8'(i));
      expectRead("R7 partial row contents", 8'h20 + 8'(i), exp);
    end
    expectRead("R6 other row ignored", 8'h31, 8'h00);
  endtask

  task automatic t_row_capture();
    busWrite(CTL, 8'h05);
    busWrite(8'h45, 8'h55);
    busWrite(8'h21, 8'h77);
    busWrite(CTL, 8'h0D);
    waitIdle();
    expectRead("R6 captured row programmed", 8'h45, 8'h55);
    expectRead("R6 write outside row dropped", 8'h21, 8'hA1);
  endtask

  task automatic t_discard();
    busWrite(CTL, 8'h05);
    busWrite(8'h50, 8'h99);
    busWrite(CTL, 8'h01);
    expectRead("R10 row mode cleared", CTL, 8'h01);
    busWrite(CTL, 8'h05);
    busWrite(CTL, 8'h0D);
    waitIdle();
    expectRead("R10 discarded byte not written", 8'h50, 8'h00);
    expectRead("R5 empty row cycle done", CTL, 8'h01);
  endtask

  task automatic t_busy();
    busWrite(8'h60, 8'h5A);
    busWrite(8'h61, 8'h6B);
    expectRead("R11 array read while busy", 8'h60, 8'h00);
    busWrite(CTL, 8'h00);
    expectRead("R11 ctl write ignored while busy", CTL, 8'h03);
    waitIdle();
    expectRead("R11 cycle completed", 8'h60, 8'h5A);
    expectRead("R11 aborted write", 8'h61, 8'h00);
    expectRead("R11 ctl after cycle", CTL, 8'h01);
  endtask

  task automatic t_standby();
    busWrite(CTL, 8'h41);
    expectRead("R12 standby readback", CTL, 8'h41);
    busWrite(8'h12, 8'hFF);
    expectRead("R12 no cycle in standby", CTL, 8'h41);
    expectRead("R12 read blocked in standby", 8'h12, 8'h00);
    busWrite(CTL, 8'h01);
    waitIdle();
    expectRead("R12 contents kept", 8'h12, 8'hA5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_wrdis();
    t_ctlbits();
    t_interlock();
    t_row_partial();
    t_row_capture();
    t_discard();
    t_busy();
    t_standby();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule